// File: doc/BRIEF.md
# Direction-Dependent Power-Fail Qualifier

This block sits behind an external voltage comparator whose digital output is high while a monitored supply is under its reference level. It turns that raw, asynchronous level into a clean active-low power-fail flag. A short disturbance, such as a radiation-induced glitch or a brief dip, must not reach the flag. A change is accepted only after the new comparator level has persisted for a set number of clock cycles.

Entry into the failure state is qualified with a longer window than the return to normal. A real brown-out is therefore confirmed with care, while recovery is reported promptly. The block keeps no voltage hysteresis of its own. Time is the only thing that separates an accepted transition from a rejected one.

The raw input first passes through a two-flop synchronizer. A single counter then runs while the synchronized level disagrees with the current flag, using the window that matches the direction of the pending change. The counter clears as soon as the two agree again.

Top module: `pwr_fail_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pf_n` is 1 (no failure). The synchronizer restarts from "not below", so the first below-level sample after reset is qualified like any other.
- R2: `raw_below` = 1 means the monitored voltage is below its reference. If `raw_below` is held at 1 starting before clock edge k, `pf_n` falls to 0 after edge k+1+FALL_CYCLES. That is FALL_CYCLES+2 edges counted from edge k.
- R3: If `raw_below` is held at 0 starting before edge k while `pf_n` is 0, `pf_n` rises to 1 after edge k+1+RISE_CYCLES.
- R4: While `pf_n` is 1, a run of 1 on `raw_below` that lasts fewer than FALL_CYCLES cycles leaves `pf_n` at 1.
- R5: While `pf_n` is 0, a run of 0 on `raw_below` that lasts fewer than RISE_CYCLES cycles, or a string of one-cycle toggles, leaves `pf_n` at 0.
- R6: Disagreeing samples do not accumulate across an agreeing sample. Any cycle in which the synchronized level matches the flag restarts the qualification window from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_below | input | 1 | Asynchronous comparator output, 1 = monitored voltage below its reference |
| pf_n | output | 1 | Registered power-fail flag, 0 = failure accepted |

## Verification
The assertions take `raw_below` to be a level that stays stable long enough around each clock edge for the synchronizer to resolve it. They treat each clock sample as exactly one cycle of persistence, so the run-length monitors in the checker count synchronized samples and not time. The stimulus keeps within this by changing `raw_below` only on the falling clock edge, at whole-cycle granularity. It holds each level for a counted number of cycles, so every run length and boundary value is exact.

// File: rtl/pff_pkg.sv
package pff_pkg;
  // width needed to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= RST_VAL;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pff_qual.sv
module pff_qual #(
  parameter int unsigned RISE_CYCLES = 7,
  parameter int unsigned FALL_CYCLES = 20,
  localparam int unsigned MAX_CYCLES = pff_pkg::max2(RISE_CYCLES, FALL_CYCLES),
  localparam int unsigned CNT_W      = pff_pkg::cnt_width(MAX_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             below,   // synchronized: 1 = under reference
  output logic             ok_q,    // 1 = no failure accepted
  output logic [CNT_W-1:0] cnt_q
);
  logic             disagree;
  logic [CNT_W-1:0] limit;

  // below=1 disagrees with ok=1; below=0 disagrees with ok=0
  assign disagree = (below == ok_q);
  // window picked by the direction of the pending change
  assign limit    = below ? CNT_W'(FALL_CYCLES - 1) : CNT_W'(RISE_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q  <= 1'b1;
      cnt_q <= '0;
    end else if (!disagree) begin
      cnt_q <= '0;
    end else if (cnt_q == limit) begin
      ok_q  <= ~ok_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_fail_filter.sv
module pwr_fail_filter #(
  parameter int unsigned RISE_CYCLES = 7,
  parameter int unsigned FALL_CYCLES = 20,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W =
    pff_pkg::cnt_width(pff_pkg::max2(RISE_CYCLES, FALL_CYCLES))
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_below,
  output logic pf_n
);
  logic             sync_below;
  logic             ok_q;
  logic [CNT_W-1:0] cnt;

  pff_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_below),
    .q_sync  (sync_below)
  );

  pff_qual #(
    .RISE_CYCLES (RISE_CYCLES),
    .FALL_CYCLES (FALL_CYCLES)
  ) u_qual (
    .clk   (clk),
    .rst   (rst),
    .below (sync_below),
    .ok_q  (ok_q),
    .cnt_q (cnt)
  );

  assign pf_n = ok_q;
endmodule

// File: rtl/pwr_fail_filter_chk.sv
module pwr_fail_filter_chk #(
  parameter int unsigned RISE_CYCLES = 7,
  parameter int unsigned FALL_CYCLES = 20,
  parameter int unsigned CNT_W       = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             raw_below,
  input logic             pf_n,
  input logic             sync_below,
  input logic [CNT_W-1:0] cnt
);
  localparam int unsigned RUN_MAX = RISE_CYCLES + FALL_CYCLES + 2;
  localparam int unsigned RUN_W   = pff_pkg::cnt_width(RUN_MAX);

  logic [RUN_W-1:0] run_hi, run_lo;

  // consecutive synchronized samples at each level, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      run_hi <= '0;
      run_lo <= '0;
    end else begin
      run_hi <= !sync_below ? '0 : (run_hi == RUN_W'(RUN_MAX)) ? run_hi : run_hi + 1'b1;
      run_lo <=  sync_below ? '0 : (run_lo == RUN_W'(RUN_MAX)) ? run_lo : run_lo + 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> pf_n); // R1

  AST_FALL_PERSIST: assert property (@(posedge clk) disable iff (rst)
    $fell(pf_n) |-> (run_hi >= RUN_W'(FALL_CYCLES))); // R2

  AST_SHORT_DIP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (pf_n && run_hi < RUN_W'(FALL_CYCLES)) |-> ##1 (pf_n || $past(sync_below))); // R4

  AST_RISE_PERSIST: assert property (@(posedge clk) disable iff (rst)
    ($rose(pf_n) && !$past(rst)) |-> (run_lo >= RUN_W'(RISE_CYCLES))); // R3

  AST_SHORT_RECOVERY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_n) |-> !$past(sync_below)); // R5

  AST_AGREE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (sync_below == !pf_n) |=> (cnt == '0)); // R6
endmodule

bind pwr_fail_filter pwr_fail_filter_chk #(
  .RISE_CYCLES (RISE_CYCLES),
  .FALL_CYCLES (FALL_CYCLES),
  .CNT_W       (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .raw_below  (raw_below),
  .pf_n       (pf_n),
  .sync_below (sync_below),
  .cnt        (cnt)
);

// File: tb/pwr_fail_filter_tb.sv
module pwr_fail_filter_tb;
  localparam int unsigned RISE = 7;
  localparam int unsigned FALL = 20;

  typedef struct packed {
    logic        raw;
    logic [7:0]  len;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  // level applied, cycles held, expected pf_n afterwards, requirement number
  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd19, 1'b1, 4'd4},  // R4: dip one short of FALL
    '{1'b0, 8'd25, 1'b1, 4'd4},  // R4
    '{1'b1, 8'd21, 1'b1, 4'd2},  // R2: one edge before latency
    '{1'b1, 8'd1,  1'b0, 4'd2},  // R2: FALL+2 edges reached
    '{1'b0, 8'd8,  1'b0, 4'd3},  // R3: one edge before latency
    '{1'b0, 8'd1,  1'b1, 4'd3},  // R3: RISE+2 edges reached
    '{1'b1, 8'd5,  1'b1, 4'd4},  // R4: short dip
    '{1'b0, 8'd20, 1'b1, 4'd4},  // R4
    '{1'b1, 8'd22, 1'b0, 4'd2},  // R2
    '{1'b0, 8'd6,  1'b0, 4'd5},  // R5: short recovery
    '{1'b1, 8'd10, 1'b0, 4'd5},  // R5
    '{1'b0, 8'd9,  1'b1, 4'd3},  // R3
    '{1'b1, 8'd15, 1'b1, 4'd6},  // R6: first part of split run
    '{1'b0, 8'd2,  1'b1, 4'd6},  // R6: agreeing gap
    '{1'b1, 8'd15, 1'b1, 4'd6},  // R6: second part, no accumulation
    '{1'b0, 8'd4,  1'b1, 4'd6},  // R6
    '{1'b1, 8'd20, 1'b1, 4'd2},  // R2: run of exactly FALL
    '{1'b0, 8'd2,  1'b0, 4'd2},  // R2: accepted two edges later
    '{1'b0, 8'd7,  1'b1, 4'd3},  // R3
    '{1'b1, 8'd22, 1'b0, 4'd2},  // R2
    '{1'b0, 8'd7,  1'b0, 4'd3},  // R3: run of exactly RISE
    '{1'b1, 8'd2,  1'b1, 4'd3},  // R3: accepted two edges later
    '{1'b1, 8'd19, 1'b1, 4'd2},  // R2
    '{1'b1, 8'd1,  1'b0, 4'd2},  // R2
    '{1'b0, 8'd6,  1'b0, 4'd5},  // R5
    '{1'b1, 8'd3,  1'b0, 4'd5}   // R5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_below = 1'b0;
  logic pf_n;
  int   errors = 0;
  int   checks = 0;
  int   cycles = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  pwr_fail_filter #(.RISE_CYCLES(RISE), .FALL_CYCLES(FALL)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .raw_below (raw_below),
    .pf_n      (pf_n)
  );

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (pf_n !== exp) begin
      errors++;
      $display("FAIL R%0d %s: pf_n=%b expected %b", req, what, pf_n, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    wait_cycles(3);
    check(1'b1, 1, "during reset");                 // R1
    rst = 1'b0;
    wait_cycles(1);
    check(1'b1, 1, "after reset release");          // R1

    for (int v = 0; v < NV; v++) begin
      raw_below = VECS[v].raw;
      wait_cycles(int'(VECS[v].len));
      check(VECS[v].exp, int'(VECS[v].req), $sformatf("vector %0d", v));
    end

    // R5: one-cycle toggling while failed never recovers
    for (int i = 0; i < 60; i++) begin
      raw_below = ~raw_below;
      wait_cycles(1);
    end
    check(1'b0, 5, "single-cycle toggles");

    // R1: reset during failure clears the flag
    raw_below = 1'b1;
    rst = 1'b1;
    wait_cycles(3);
    check(1'b1, 1, "reset during failure");
    // R1/R2: first below sample after reset is qualified again
    rst = 1'b0;
    wait_cycles(FALL + 1);
    check(1'b1, 1, "first sample still qualifying");
    wait_cycles(1);
    check(1'b0, 2, "first sample accepted");

    finish_run();
  end
endmodule